// File: doc/BRIEF.md
# Dark Column Black Level Clamp

This block sits behind the converter of one sensor output channel. It takes a digitized line as a stream of samples, where a start marker flags the first sample of each line. A column map follows the position of each sample inside the line and sorts it into one of six classes:

- leading dummy phases
- excluded edge dark columns
- selected central dark columns
- buffer columns
- active pixels
- trailing or unframed samples, which are ignored

Only the selected central dark columns feed the black reference. That reference is their rounded mean, formed by multiplying by a reciprocal. It is subtracted, with a floor at zero, from every active pixel of the same line.

The clamped active pixels leave the block with a valid flag. A static control input decides whether the buffer columns are also forwarded unchanged, marked with a flag, or dropped. The reference appears on a side output with a one-cycle strobe each time it is refreshed. It holds its value until the next complete dark region has been seen.

Top module: `dark_clamp`

## Requirements
- R1: While reset is held and just after it, out_valid and ref_valid are 0 and ref_data is 0.
- R2: The column position counts only samples with in_valid high. The first N_DUMMY samples of a line (default 11) never influence ref_data.
- R3: The N_DARK columns (default 22) that follow the dummy phases are dark. Of these, the first and last N_EDGE (default 1) are excluded, and only the N_DARK-2*N_EDGE central ones (default 20) contribute to the reference.
- R4: ref_data becomes floor((S + N/2) / N), where S is the sum of the selected dark samples and N is their count. ref_valid pulses high for exactly one cycle when ref_data is updated, and ref_data holds between updates.
- R5: For each active pixel p, out_data = p - ref when p > ref and 0 otherwise. ref is the reference computed from the same line, and out_buf is 0.
- R6: The N_BUF buffer columns (default 12) never affect the reference. With keep_buf=1 they are output unchanged with out_buf=1. With keep_buf=0 they produce no output.
- R7: Each forwarded sample appears on the outputs exactly 2 clock cycles after it is accepted. A complete line yields exactly N_ACT active outputs (default 1648).
- R8: Samples that arrive after the last active pixel of a line, and before the next line start, produce no output and do not change the reference.
- R9: A line start restarts the column map and discards any partial dark sum, even in the middle of a line.
- R10: Samples that arrive after reset and before the first line start are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample is present |
| in_sol | input | 1 | Marks the first sample of a line (qualified by in_valid) |
| in_data | input | DW | Digitized sample value |
| keep_buf | input | 1 | 1: forward buffer columns unchanged; 0: drop them |
| out_valid | output | 1 | Output sample is present |
| out_data | output | DW | Clamped active pixel, or unchanged buffer sample |
| out_buf | output | 1 | Output sample is a buffer column |
| ref_valid | output | 1 | One-cycle strobe when ref_data is refreshed |
| ref_data | output | DW | Current black reference |

## Verification
If the column counter is off by one, the port symptoms show up within the same line:
- If a dummy or edge dark value enters the sum, ref_data is wrong at the strobe that follows the last central dark column.
- The count of active outputs also changes by one in that same line.

The rounding and saturation arithmetic is checked with values chosen to land exactly at the rounding boundary and below the reference. A slipped pipeline register shows as a first output that appears one cycle early or late. The restart and trailing-sample cases catch a map that fails to clear on a line start, or one that keeps producing output after the active region.

// File: rtl/dclamp_pkg.sv
package dclamp_pkg;

  // Class assigned to one incoming sample by the column map
  typedef enum logic [2:0] {
    COL_NONE      = 3'd0,
    COL_DUMMY     = 3'd1,
    COL_DARK_EDGE = 3'd2,
    COL_DARK_SEL  = 3'd3,
    COL_BUF       = 3'd4,
    COL_ACT       = 3'd5
  } col_e;

endpackage

// File: rtl/dclamp_colmap.sv
module dclamp_colmap
  import dclamp_pkg::*;
#(
  parameter int N_DUMMY = 11,
  parameter int N_DARK  = 22,
  parameter int N_EDGE  = 1,
  parameter int N_BUF   = 12,
  parameter int N_ACT   = 1648
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sol,
  output col_e cls,
  output logic last_sel,
  output logic line_live
);

  localparam int TOTAL   = N_DUMMY + N_DARK + N_BUF + N_ACT;
  localparam int CW      = $clog2(TOTAL + 1);
  localparam int SEL_LO  = N_DUMMY + N_EDGE;
  localparam int SEL_HI  = N_DUMMY + N_DARK - N_EDGE;
  localparam int DARK_HI = N_DUMMY + N_DARK;
  localparam int BUF_HI  = DARK_HI + N_BUF;

  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_cur;
  logic          in_line_q;

  // Region lookup for a column position
  function automatic col_e classify(input logic [CW-1:0] i);
    if (i < CW'(N_DUMMY))      return COL_DUMMY;
    else if (i < CW'(SEL_LO))  return COL_DARK_EDGE;
    else if (i < CW'(SEL_HI))  return COL_DARK_SEL;
    else if (i < CW'(DARK_HI)) return COL_DARK_EDGE;
    else if (i < CW'(BUF_HI))  return COL_BUF;
    else if (i < CW'(TOTAL))   return COL_ACT;
    else                       return COL_NONE;
  endfunction

  assign idx_cur   = in_sol ? '0 : idx_q;
  assign line_live = in_sol | in_line_q;

  always_comb begin
    cls      = (in_valid && line_live) ? classify(idx_cur) : COL_NONE;
    last_sel = (cls == COL_DARK_SEL) && (idx_cur == CW'(SEL_HI - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      in_line_q <= 1'b0;
    end else if (in_valid) begin
      if (in_sol) begin
        idx_q     <= CW'(1);
        in_line_q <= (TOTAL > 1);
      end else if (in_line_q) begin
        idx_q <= idx_q + CW'(1);
        if (idx_q == CW'(TOTAL - 1)) in_line_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dclamp_refacc.sv
module dclamp_refacc #(
  parameter int  DW   = 12,
  parameter int  NSEL = 20,
  localparam int SUMW = DW + $clog2(NSEL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_fire,
  input  logic            sol_fire,
  input  logic            last_sel,
  input  logic [DW-1:0]   px,
  output logic [SUMW-1:0] acc_q,
  output logic [DW-1:0]   blk_q,
  output logic            blk_pulse
);

  // Exact rounded division by a reciprocal: x*n stays below 2^SH
  localparam int NW = $clog2(NSEL) + 1;
  localparam int SH = SUMW + 1 + NW;
  localparam logic [63:0] RECIP = ((64'd1 << SH) + 64'(NSEL) - 64'd1) / 64'(NSEL);

  function automatic logic [DW-1:0] rnd_div(input logic [SUMW-1:0] s);
    logic [63:0] x;
    logic [63:0] p;
    x = 64'(s) + 64'(NSEL / 2);
    p = x * RECIP;
    return DW'(p >> SH);
  endfunction

  logic [SUMW-1:0] acc_base;
  logic [SUMW-1:0] acc_next;
  logic [SUMW-1:0] sum_q;
  logic            sum_rdy;

  always_comb begin
    acc_base = sol_fire ? '0 : acc_q;
    acc_next = acc_base + (sel_fire ? SUMW'(px) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      sum_q     <= '0;
      sum_rdy   <= 1'b0;
      blk_q     <= '0;
      blk_pulse <= 1'b0;
    end else begin
      if (sol_fire || sel_fire) acc_q <= acc_next;
      sum_rdy <= sel_fire && last_sel;
      if (sel_fire && last_sel) sum_q <= acc_next;
      blk_pulse <= sum_rdy;
      if (sum_rdy) blk_q <= rnd_div(sum_q);
    end
  end

endmodule

// File: rtl/dclamp_sub.sv
module dclamp_sub
  import dclamp_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  col_e          cls,
  input  logic          keep_buf,
  input  logic [DW-1:0] px,
  input  logic [DW-1:0] blk,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_buf
);

  function automatic logic [DW-1:0] sat_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  logic          s1_act;
  logic          s1_buf;
  logic [DW-1:0] s1_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_act    <= 1'b0;
      s1_buf    <= 1'b0;
      s1_data   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_buf   <= 1'b0;
    end else begin
      s1_act    <= (cls == COL_ACT);
      s1_buf    <= (cls == COL_BUF) && keep_buf;
      s1_data   <= px;
      out_valid <= s1_act || s1_buf;
      out_buf   <= s1_buf;
      out_data  <= s1_act ? sat_sub(s1_data, blk) : s1_data;
    end
  end

endmodule

// File: rtl/dark_clamp.sv
module dark_clamp
  import dclamp_pkg::*;
#(
  parameter int DW      = 12,
  parameter int N_DUMMY = 11,
  parameter int N_DARK  = 22,
  parameter int N_EDGE  = 1,
  parameter int N_BUF   = 12,
  parameter int N_ACT   = 1648
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic [DW-1:0] in_data,
  input  logic          keep_buf,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_buf,
  output logic          ref_valid,
  output logic [DW-1:0] ref_data
);

  localparam int NSEL = N_DARK - 2 * N_EDGE;
  localparam int SUMW = DW + $clog2(NSEL + 1);

  col_e            cls;
  logic            last_sel;
  logic            line_live;
  logic            sel_fire;
  logic            sol_fire;
  logic [SUMW-1:0] acc_q;

  assign sel_fire = (cls == COL_DARK_SEL);
  assign sol_fire = in_valid && in_sol;

  dclamp_colmap #(
    .N_DUMMY(N_DUMMY), .N_DARK(N_DARK), .N_EDGE(N_EDGE),
    .N_BUF(N_BUF), .N_ACT(N_ACT)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .cls(cls), .last_sel(last_sel), .line_live(line_live)
  );

  dclamp_refacc #(.DW(DW), .NSEL(NSEL)) u_acc (
    .clk(clk), .rst_n(rst_n), .sel_fire(sel_fire), .sol_fire(sol_fire),
    .last_sel(last_sel), .px(in_data), .acc_q(acc_q),
    .blk_q(ref_data), .blk_pulse(ref_valid)
  );

  dclamp_sub #(.DW(DW)) u_sub (
    .clk(clk), .rst_n(rst_n), .cls(cls), .keep_buf(keep_buf),
    .px(in_data), .blk(ref_data),
    .out_valid(out_valid), .out_data(out_data), .out_buf(out_buf)
  );

endmodule

// File: rtl/dark_clamp_chk.sv
module dark_clamp_chk
  import dclamp_pkg::*;
#(
  parameter int DW   = 12,
  parameter int SUMW = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_sol,
  input logic            keep_buf,
  input logic            out_valid,
  input logic            out_buf,
  input logic            ref_valid,
  input logic [DW-1:0]   ref_data,
  input col_e            cls,
  input logic            line_live,
  input logic [SUMW-1:0] acc_q
);

  // R2 R3 R6 R8: samples outside the central dark window leave the sum untouched
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_sol) && cls != COL_DARK_SEL) |=> $stable(acc_q));

  // R9: a line start whose sample is not a selected dark column clears the sum
  p_sol_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sol && cls != COL_DARK_SEL) |=> (acc_q == '0));

  // R4: the refresh strobe lasts one cycle
  p_ref_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> !ref_valid);

  // R4: the reference changes only together with its strobe
  p_ref_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_data) |-> ref_valid);

  // R7: every output has an accepted input two cycles earlier
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R6: buffer outputs only when forwarding was enabled for that sample
  p_buf_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_buf) |-> $past(keep_buf, 2));

  // R8 R10: unframed samples produce nothing
  p_tail_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !line_live) |-> ##2 !out_valid);

endmodule

bind dark_clamp dark_clamp_chk #(.DW(DW), .SUMW(SUMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
  .keep_buf(keep_buf), .out_valid(out_valid), .out_buf(out_buf),
  .ref_valid(ref_valid), .ref_data(ref_data), .cls(cls),
  .line_live(line_live), .acc_q(acc_q)
);

// File: tb/dark_clamp_test.sv
module dark_clamp_test;

  localparam int DW      = 12;
  localparam int N_DUMMY = 11;
  localparam int N_DARK  = 22;
  localparam int N_EDGE  = 1;
  localparam int N_BUF   = 12;
  localparam int N_ACT   = 1648;
  localparam int TOTAL   = N_DUMMY + N_DARK + N_BUF + N_ACT;
  localparam int SEL_LO  = N_DUMMY + N_EDGE;
  localparam int SEL_HI  = N_DUMMY + N_DARK - N_EDGE;
  localparam int BUF_LO  = N_DUMMY + N_DARK;
  localparam int ACT_LO  = BUF_LO + N_BUF;
  localparam int NSEL    = SEL_HI - SEL_LO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_sol = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          keep_buf = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_buf;
  logic          ref_valid;
  logic [DW-1:0] ref_data;

  dark_clamp #(
    .DW(DW), .N_DUMMY(N_DUMMY), .N_DARK(N_DARK), .N_EDGE(N_EDGE),
    .N_BUF(N_BUF), .N_ACT(N_ACT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_data(in_data), .keep_buf(keep_buf), .out_valid(out_valid),
    .out_data(out_data), .out_buf(out_buf), .ref_valid(ref_valid),
    .ref_data(ref_data)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nerr = 0;
  int line_px [TOTAL];
  int cap_v [4096];
  int cap_b [4096];
  int cap_t [4096];
  int ncap = 0;
  int nref = 0;
  int ref_seen = 0;
  int t_first = 0;

  always @(negedge clk) begin
    if (out_valid && ncap < 4096) begin
      cap_v[ncap] = int'(out_data);
      cap_b[ncap] = int'(out_buf);
      cap_t[ncap] = cyc;
      ncap = ncap + 1;
    end
    if (ref_valid) begin
      nref = nref + 1;
      ref_seen = int'(ref_data);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill_line(input int dummy_v, input int edge_v, input int sel_v,
                           input int buf_v, input int act_base, input int act_step,
                           input int act_mod);
    for (int i = 0; i < TOTAL; i++) begin
      if (i < N_DUMMY) line_px[i] = dummy_v;
      else if (i < SEL_LO || (i >= SEL_HI && i < BUF_LO)) line_px[i] = edge_v;
      else if (i < SEL_HI) line_px[i] = sel_v;
      else if (i < ACT_LO) line_px[i] = buf_v;
      else line_px[i] = act_base + ((i - ACT_LO) * act_step) % act_mod;
    end
  endtask

  task automatic clear_cap();
    ncap = 0;
    nref = 0;
  endtask

  // Drive n samples of line_px, idle gaps optional, then tail samples
  task automatic send_line(input int n, input bit gaps, input int tail_n);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7) == 3) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_data  = 12'hABC;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sol   = (i == 0);
      in_data  = DW'(line_px[i]);
      if (i == ACT_LO) t_first = cyc;
    end
    for (int k = 0; k < tail_n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sol   = 1'b0;
      in_data  = DW'(4000);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sol   = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  function automatic int exp_ref();
    int s = 0;
    for (int i = SEL_LO; i < SEL_HI; i++) s += line_px[i];
    return (s + NSEL / 2) / NSEL;
  endfunction

  task automatic check_line(input string tag, input bit keep);
    int r;
    int n_exp;
    int nbad;
    int bad_a;
    int bad_e;
    int off;
    r = exp_ref();
    n_exp = N_ACT + (keep ? N_BUF : 0);
    off = keep ? N_BUF : 0;
    chk(nref == 1, "R4", {tag, " ref strobes"}, nref, 1);
    chk(ref_seen == r, "R4", {tag, " ref value"}, ref_seen, r);
    chk(int'(ref_data) == r, "R4", {tag, " ref held"}, int'(ref_data), r);
    chk(ncap == n_exp, "R7", {tag, " output count"}, ncap, n_exp);
    nbad = 0; bad_a = 0; bad_e = 0;
    for (int j = 0; j < ncap && j < n_exp; j++) begin
      int e;
      int eb;
      if (j < off) begin
        e = line_px[BUF_LO + j];
        eb = 1;
      end else begin
        e = line_px[ACT_LO + j - off] - r;
        if (e < 0) e = 0;
        eb = 0;
      end
      if (cap_v[j] != e || cap_b[j] != eb) begin
        if (nbad == 0) begin bad_a = cap_v[j]; bad_e = e; end
        nbad++;
      end
    end
    chk(nbad == 0, "R5", {tag, " clamped values"}, bad_a, bad_e);
    if (ncap > off)
      chk(cap_t[off] == t_first + 2, "R7", {tag, " first active latency"},
          cap_t[off] - t_first, 2);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(ref_valid == 1'b0, "R1", "ref_valid in reset", int'(ref_valid), 0);
    chk(ref_data == '0, "R1", "ref_data in reset", int'(ref_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && ref_data == '0, "R1", "idle after reset",
        int'(out_valid), 0);
    clear_cap();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sol   = 1'b0;
      in_data  = DW'(k * 13);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(ncap == 0, "R10", "outputs before first line start", ncap, 0);
    chk(nref == 0, "R10", "ref strobes before first line start", nref, 0);
  endtask

  task automatic t_flat();
    keep_buf = 1'b0;
    fill_line(100, 100, 100, 100, 500, 7, 300);
    clear_cap();
    send_line(TOTAL, 1'b0, 0);
    check_line("flat", 1'b0);
  endtask

  task automatic t_edges();
    keep_buf = 1'b0;
    fill_line(4095, 4095, 150, 4095, 200, 3, 1000);
    clear_cap();
    send_line(TOTAL, 1'b0, 0);
    chk(ref_seen == 150, "R3", "edge and dummy exclusion", ref_seen, 150);
    chk(ref_seen == 150, "R2", "dummy phases ignored", ref_seen, 150);
    check_line("edges", 1'b0);
  endtask

  task automatic t_rounding();
    keep_buf = 1'b0;
    fill_line(0, 0, 10, 0, 50, 1, 40);
    line_px[SEL_LO] = 20;
    clear_cap();
    send_line(TOTAL, 1'b0, 0);
    chk(ref_seen == 11, "R4", "half rounds up", ref_seen, 11);
    check_line("round_up", 1'b0);
    fill_line(0, 0, 10, 0, 50, 1, 40);
    line_px[SEL_HI - 1] = 19;
    clear_cap();
    send_line(TOTAL, 1'b0, 0);
    chk(ref_seen == 10, "R4", "below half rounds down", ref_seen, 10);
    check_line("round_down", 1'b0);
  endtask

  task automatic t_saturate();
    keep_buf = 1'b0;
    fill_line(50, 3000, 300, 2000, 0, 53, 601);
    clear_cap();
    send_line(TOTAL, 1'b0, 0);
    check_line("saturate", 1'b0);
    chk(cap_v[0] == 0, "R5", "pixel 0 below reference", cap_v[0], 0);
  endtask

  task automatic t_keep_buffer();
    keep_buf = 1'b1;
    fill_line(60, 60, 80, 4095, 1000, 11, 500);
    clear_cap();
    send_line(TOTAL, 1'b0, 0);
    chk(cap_b[0] == 1 && cap_v[0] == 4095, "R6", "buffer forwarded raw",
        cap_v[0], 4095);
    chk(ref_seen == 80, "R6", "buffer excluded from ref", ref_seen, 80);
    check_line("keep_buf", 1'b1);
    keep_buf = 1'b0;
  endtask

  task automatic t_gaps_tail();
    keep_buf = 1'b0;
    fill_line(900, 900, 40, 900, 100, 17, 900);
    clear_cap();
    send_line(TOTAL, 1'b1, 60);
    chk(ref_seen == 40, "R2", "idle cycles do not advance map", ref_seen, 40);
    chk(ncap == N_ACT, "R8", "trailing samples silent", ncap, N_ACT);
    chk(int'(ref_data) == 40, "R8", "trailing samples keep ref", int'(ref_data), 40);
    check_line("gaps", 1'b0);
  endtask

  task automatic t_restart();
    keep_buf = 1'b0;
    fill_line(900, 900, 900, 900, 900, 1, 10);
    clear_cap();
    send_line(SEL_LO + 8, 1'b0, 0);
    chk(ncap == 0 && nref == 0, "R9", "partial line no output", ncap + nref, 0);
    fill_line(700, 700, 55, 700, 300, 29, 700);
    clear_cap();
    send_line(TOTAL, 1'b0, 0);
    chk(ref_seen == 55, "R9", "partial dark sum discarded", ref_seen, 55);
    check_line("restart", 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        t_reset();
        t_flat();
        t_edges();
        t_rounding();
        t_saturate();
        t_keep_buffer();
        t_gaps_tail();
        t_restart();
      end
      begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule